// File: doc/BRIEF.md
# Synchronous Selectable Clock Divider

This block derives two divided clocks from one input clock. Bank A runs at one half or one quarter of the input rate. Bank B runs at one quarter or one sixth. Each bank has its own select input. Both banks advance from a single twelve-state phase register. Because of that, every rising edge the two outputs have in common falls on the same input-clock edge, and the two banks cannot drift apart, even without a reset.

A common enable is captured on the falling edge of the input clock. The dividers therefore start and stop only between input pulses, never part way through one. A request to stop is honoured at the next point where both outputs are low: the chain halts there, and the outputs stay low until the enable returns. Select changes are taken at that same all-low point, so no output period is ever cut short.

An asynchronous master reset puts every flop in a defined state. Several instances that leave reset together therefore produce phase-aligned outputs.

Top module: `sel_clk_div`

## Requirements
- R1: While `mr` is high, both outputs are low immediately, and both latched selects read as 0. After release, the first rising edge on the outputs comes at the first rising `clk` edge that follows a falling edge at which `en` was high and `mr` was low.
- R2: Bank A with the latched select at 0 gives a period of 2 `clk` cycles: high 1, low 1. With the latched select at 1 it gives a period of 4: high 2, low 2.
- R3: Bank B with the latched select at 0 gives a period of 4: high 2, low 2. With the latched select at 1 it gives a period of 6: high 3, low 3.
- R4: Both outputs rise on the same `clk` edge at the start of every twelve-cycle frame, whatever the selects are.
- R5: `en` is sampled only on the falling edge of `clk`. A change in `en` acts at the next rising edge.
- R6: When `en` is sampled low, the dividers keep running until the all-low boundary, which is the cycle just before a common rising edge. They then hold there, both outputs low and unchanging, for as long as `en` stays low.
- R7: When `en` is sampled high again after a hold, both outputs rise at the very next rising edge of `clk`.
- R8: `sel_a` and `sel_b` are captured only at the all-low boundary. Every high pulse lasts exactly half of the period that was selected when it began.
- R9: With `en`, `mr`, `sel_a` and `sel_b` all held low, both outputs stay low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock to be divided |
| mr | input | 1 | Asynchronous master reset, active high |
| en | input | 1 | Common run enable, sampled on falling `clk` |
| sel_a | input | 1 | Bank A ratio: 0 selects divide by 2, 1 selects divide by 4 |
| sel_b | input | 1 | Bank B ratio: 0 selects divide by 4, 1 selects divide by 6 |
| out_a | output | 1 | Bank A divided clock |
| out_b | output | 1 | Bank B divided clock |

## Verification
The bench drives inputs 1 ns after a rising edge, so the falling edge that follows captures `en`. Outputs are registered, so a given drive shows up at the next rising edge, and the bench samples there, 1 ns later. A reset is the one exception: it clears the outputs at once, and the bench checks it in the same interval. A bench-side phase model moves by the same one-edge rule, so each sample is compared against the cycle it belongs to. Pulse widths are measured at the fall of each pulse against the ratio that was in force when the pulse rose.

// File: rtl/sel_clk_div.sv
module sel_clk_div (
  input  logic clk,
  input  logic mr,
  input  logic en,
  input  logic sel_a,
  input  logic sel_b,
  output logic out_a,
  output logic out_b
);

  localparam int PHASES = 12;
  localparam int PW = $clog2(PHASES);
  localparam logic [PW-1:0] LAST = PW'(PHASES - 1);

  logic          en_q;
  logic [PW-1:0] ph, ph_n;
  logic          sa_q, sb_q, sa_n, sb_n;
  logic          at_edge, adv;

  always_ff @(negedge clk or posedge mr)
    if (mr) en_q <= 1'b0;
    else    en_q <= en;

  assign at_edge = (ph == LAST);
  assign adv     = en_q | ~at_edge;
  assign ph_n    = at_edge ? '0 : ph + 1'b1;
  assign sa_n    = at_edge ? sel_a : sa_q;
  assign sb_n    = at_edge ? sel_b : sb_q;

  function automatic logic bank_a(input logic [PW-1:0] p, input logic s);
    return s ? ~p[1] : ~p[0];
  endfunction

  function automatic logic bank_b(input logic [PW-1:0] p, input logic s);
    return s ? (p < PW'(3)) || (p >= PW'(6) && p < PW'(9)) : ~p[1];
  endfunction

  always_ff @(posedge clk or posedge mr)
    if (mr) begin
      ph    <= LAST;
      sa_q  <= 1'b0;
      sb_q  <= 1'b0;
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else if (adv) begin
      ph    <= ph_n;
      sa_q  <= sa_n;
      sb_q  <= sb_n;
      out_a <= bank_a(ph_n, sa_n);
      out_b <= bank_b(ph_n, sb_n);
    end

  always @(negedge clk)
    if (mr) a_r1_rst_low: assert (!out_a && !out_b);

  a_r6_hold_low: assert property (@(posedge clk) disable iff (mr)
    (at_edge && !en_q) |=> ($stable(ph) && !out_a && !out_b));

  a_r8_sel_boundary: assert property (@(posedge clk) disable iff (mr)
    !at_edge |=> ($stable(sa_q) && $stable(sb_q)));

  a_r4_common_rise: assert property (@(posedge clk) disable iff (mr)
    (ph == '0) |-> (out_a && out_b));

  a_r2_quarter_match: assert property (@(posedge clk) disable iff (mr)
    (sa_q && !sb_q) |-> (out_a == out_b));

endmodule

// File: tb/tb_sel_clk_div.sv
`timescale 1ns/1ps
module tb_sel_clk_div;
  logic clk = 1'b0, mr = 1'b1, en = 1'b0, sel_a = 1'b0, sel_b = 1'b0;
  logic out_a, out_b;

  sel_clk_div dut (.clk(clk), .mr(mr), .en(en), .sel_a(sel_a), .sel_b(sel_b),
                   .out_a(out_a), .out_b(out_b));

  always #2 clk = ~clk;

  int vectors = 0, errors = 0;
  int m_ph = 11;
  bit m_sa = 0, m_sb = 0, e_a = 0, e_b = 0;
  int run_a = 0, run_b = 0, half_a = 0, half_b = 0;
  bit prev_a = 0, prev_b = 0;
  bit done = 0;

  function automatic bit fa(int p, bit s);
    return s ? (p % 4 < 2) : (p % 2 == 0);
  endfunction
  function automatic bit fb(int p, bit s);
    return s ? (p % 6 < 3) : (p % 4 < 2);
  endfunction

  task automatic chk(string tag, bit act_a, bit act_b, bit exp_a, bit exp_b);
    vectors++;
    if (act_a !== exp_a || act_b !== exp_b) begin
      errors++;
      $display("FAIL %s: out_a/out_b = %b%b expected %b%b at %0t", tag, act_a, act_b, exp_a, exp_b, $time);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  endtask

  // Drive at posedge+1, then check the result at the next posedge+1.
  task automatic cyc(bit e, bit sa, bit sb, bit r);
    string tag;
    bit adv;
    en = e; sel_a = sa; sel_b = sb; mr = r;
    if (r) begin
      m_ph = 11; m_sa = 0; m_sb = 0;
      #0.5;
      chk("R1 async", out_a, out_b, 1'b0, 1'b0);
      run_a = 0; run_b = 0;
    end
    @(posedge clk); #1;
    adv = !r && (e || m_ph != 11);
    tag = r ? "R1" : (!adv ? "R6" : (m_ph == 11 ? "R8" : "R2 R3"));
    if (adv) begin
      if (m_ph == 11) begin m_sa = sa; m_sb = sb; m_ph = 0; end
      else m_ph++;
    end
    e_a = r ? 1'b0 : fa(m_ph, m_sa);
    e_b = r ? 1'b0 : fb(m_ph, m_sb);
    chk(tag, out_a, out_b, e_a, e_b);
    if (adv && m_ph == 0) chk("R4", out_a, out_b, 1'b1, 1'b1);
    // R8: pulse widths against the ratio in force at the rise
    if (out_a && !prev_a) begin half_a = m_sa ? 2 : 1; run_a = 0; end
    if (out_b && !prev_b) begin half_b = m_sb ? 3 : 2; run_b = 0; end
    if (out_a) run_a++;
    if (out_b) run_b++;
    if (!out_a && prev_a && run_a != 0) begin
      vectors++;
      if (run_a != half_a) begin errors++; $display("FAIL R8: out_a high %0d expected %0d", run_a, half_a); end
    end
    if (!out_b && prev_b && run_b != 0) begin
      vectors++;
      if (run_b != half_b) begin errors++; $display("FAIL R8: out_b high %0d expected %0d", run_b, half_b); end
    end
    prev_a = out_a; prev_b = out_b;
  endtask

  initial begin
    #600000;
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
  end

  initial begin
    @(posedge clk); #1;
    chk("R1 reset", out_a, out_b, 1'b0, 1'b0);
    // R9: everything low
    for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0);
    for (int i = 0; i < 10; i++) cyc(0, 0, 0, 0);
    // R1/R7: first rise one edge after enable captured
    cyc(1, 0, 0, 0);
    chk("R7 first rise", out_a, out_b, 1'b1, 1'b1);
    // R2/R3: every select combination, two frames each
    for (int c = 0; c < 4; c++)
      for (int i = 0; i < 24; i++) cyc(1, c[0], c[1], 0);
    // R5/R6: disable mid-frame, runs on to boundary then holds
    for (int i = 0; i < 5; i++) cyc(1, 1, 1, 0);
    for (int i = 0; i < 20; i++) cyc(0, 1, 1, 0);
    chk("R6 held low", out_a, out_b, 1'b0, 1'b0);
    // R8: select change while held takes effect at restart
    cyc(0, 0, 0, 0);
    cyc(1, 0, 0, 0);
    chk("R5 R7 restart", out_a, out_b, 1'b1, 1'b1);
    for (int i = 0; i < 12; i++) cyc(1, 0, 1, 0);
    // R1: mid-run reset
    cyc(1, 1, 1, 1);
    cyc(1, 1, 1, 1);
    for (int i = 0; i < 12; i++) cyc(1, 1, 0, 0);
    // random phase, fixed seed
    void'($urandom(32'h5eed));
    begin
      bit e = 1, sa = 0, sb = 0;
      for (int i = 0; i < 5000; i++) begin
        if ($urandom_range(0, 15) == 0) e = ~e;
        if ($urandom_range(0, 9) == 0) sa = $urandom_range(0, 1);
        if ($urandom_range(0, 9) == 0) sb = $urandom_range(0, 1);
        cyc(e, sa, sb, $urandom_range(0, 499) == 0);
      end
    end
    report();
  end
endmodule